// File: doc/BRIEF.md
# Synthesizer Frequency Word Calculator

This block turns a requested receive carrier and a requested transmit carrier, both in hertz, into the two 32-bit frequency-setting words for a fractional-N synthesizer. Each word carries an 8-bit integer divider N and a 15-bit fractional divider F. The control bits in each word select the receive or the transmit path, and they also encode whether the radio data line is shared or bidirectional.

The receive target is the receive carrier minus a fixed 100 kHz intermediate frequency, plus a per-mode frequency-correction offset. That offset is zero for the constant-envelope mode and nonzero for the four-level modes. The offset is added twice when the band runs its oscillator at double rate. The transmit target is the transmit carrier alone. Each target is divided by half the phase-detector frequency in normal bands and by the full phase-detector frequency in double-rate bands. The fraction is rounded to the nearest 1/32768 step.

A single pulse on `start` samples all the inputs. Two serial dividers then work in parallel, one per direction. When both results are packed into the output words, `done` pulses once. The words then hold until the next completed calculation.

Top module: `synth_word_calc`

## Requirements
- R1: While reset is high and after it is released, `busy` and `done` are 0 and both output words are 0.
- R2: A `start` seen while `busy` is low makes `busy` high from the next cycle for exactly 51 cycles. `done` rises in the cycle where `busy` falls and stays high for one cycle only.
- R3: With `div2` clear, the receive target is `rx_freq_hz - 100000 + afc_ofs_hz`, and it is divided by PFD_HZ/2.
- R4: With `div2` set, the receive target is `rx_freq_hz - 100000 + 2*afc_ofs_hz`, and both targets are divided by PFD_HZ.
- R5: The transmit target is `tx_freq_hz` itself, with no IF subtraction and no offset.
- R6: N is the integer quotient. F is the remainder times 32768 divided by the divisor, rounded to nearest. When the rounding gives F = 32768, F becomes 0 and N grows by one.
- R7: Each word holds 0000 in bits 3..0, F in bits 18..4 and N in bits 26..19.
- R8: Bits 31..27 are 01011 (receive) and 01010 (transmit) when `bidir_data` is 0. They are 01001 and 01000 when `bidir_data` is 1. The value used is the one sampled at start.
- R9: A `start` while `busy` is high is ignored. Input changes after the accepted start do not affect the result.
- R10: N is kept modulo 256: an integer quotient of 256 or more keeps only its low 8 bits.
- R11: Both output words change only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| rx_freq_hz | input | 32 | Requested receive carrier, Hz |
| tx_freq_hz | input | 32 | Requested transmit carrier, Hz |
| afc_ofs_hz | input | 16 | Per-mode frequency-correction offset, Hz |
| div2 | input | 1 | Band uses double-rate oscillator |
| bidir_data | input | 1 | Data line is bidirectional |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: both words updated |
| rx_word | output | 32 | Packed receive word |
| tx_word | output | 32 | Packed transmit word |

## Verification
The bench aims at a transmit carrier whose remainder rounds up to a full step. A design without the carry would show F as all ones or put a stray bit into N, instead of F = 0 with N one higher. It also drives a quotient above 255 to show N wrapping, and a double-rate band where a design that forgets to double the offset, or divides by the wrong reference, lands on a different N/F pair. A second start during a calculation, together with new inputs, checks that a design that restarts or samples late does not corrupt the words. The cycle-by-cycle busy/done model catches any change in latency.

// File: rtl/wfc_pkg.sv
package wfc_pkg;
    localparam int FREQ_W = 32;
    localparam int OFS_W  = 16;
    localparam int FRAC_W = 15;
    localparam int N_W    = 8;
    localparam int TGT_W  = FREQ_W + 2;
    localparam int DVD_W  = TGT_W + FRAC_W + 1;
    localparam int DSR_W  = 32;
    localparam int RES_W  = N_W + FRAC_W;
    localparam int CTRL_W = 5;
    localparam logic [3:0] REG_ADDR = 4'b0000;

    typedef enum logic {LANE_RX = 1'b0, LANE_TX = 1'b1} lane_e;

    typedef struct packed {
        logic [N_W-1:0]    n;
        logic [FRAC_W-1:0] f;
    } divs_t;

    function automatic logic [CTRL_W-1:0] ctrl_bits(lane_e lane, logic bidir);
        return {3'b010, ~bidir, (lane == LANE_RX)};
    endfunction

    function automatic logic [31:0] pack_word(lane_e lane, logic bidir, divs_t d);
        return {ctrl_bits(lane, bidir), d.n, d.f, REG_ADDR};
    endfunction
endpackage

// File: rtl/wfc_target.sv
module wfc_target
    import wfc_pkg::*;
#(
    parameter int unsigned PFD_HZ = 3686400,
    parameter int unsigned IF_HZ  = 100000
) (
    input  logic [FREQ_W-1:0]           rx_freq,
    input  logic [FREQ_W-1:0]           tx_freq,
    input  logic [OFS_W-1:0]            afc,
    input  logic                        div2,
    output logic [1:0][DVD_W-1:0]       dvd,
    output logic [DSR_W-1:0]            dsr
);
    localparam logic [DSR_W-1:0] DSR_FULL = DSR_W'(PFD_HZ);
    localparam logic [DSR_W-1:0] DSR_HALF = DSR_W'(PFD_HZ / 2);
    localparam logic [TGT_W-1:0] IF_T     = TGT_W'(IF_HZ);

    logic [TGT_W-1:0] afc_adj;
    logic [1:0][TGT_W-1:0] tgt;

    always_comb begin
        dsr     = div2 ? DSR_FULL : DSR_HALF;
        afc_adj = div2 ? TGT_W'({afc, 1'b0}) : TGT_W'(afc);
        tgt[LANE_RX] = TGT_W'(rx_freq) - IF_T + afc_adj;
        tgt[LANE_TX] = TGT_W'(tx_freq);
    end

    // Scaled target plus half divisor: one division yields N and rounded F
    for (genvar gi = 0; gi < 2; gi++) begin : g_scale
        assign dvd[gi] = DVD_W'({tgt[gi], {FRAC_W{1'b0}}}) + DVD_W'(dsr >> 1);
    end
endmodule

// File: rtl/wfc_divider.sv
module wfc_divider #(
    parameter int DVD_W = 50,
    parameter int DSR_W = 32,
    parameter int OUT_W = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DVD_W-1:0] dvd,
    input  logic [DSR_W-1:0] dsr,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] quot
);
    localparam int CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

    logic [DVD_W-1:0] q;
    logic [DSR_W-1:0] rem;
    logic [DSR_W-1:0] dsr_q;
    logic [CNT_W-1:0] cnt;
    logic [DSR_W:0]   rem_sh;
    logic             ge;

    always_comb begin
        rem_sh = {rem, q[DVD_W-1]};
        ge     = rem_sh >= {1'b0, dsr_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            rem   <= '0;
            dsr_q <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load && !busy) begin
                q     <= dvd;
                rem   <= '0;
                dsr_q <= dsr;
                cnt   <= '0;
                busy  <= 1'b1;
            end else if (busy) begin
                q   <= {q[DVD_W-2:0], ge};
                rem <= ge ? DSR_W'(rem_sh - {1'b0, dsr_q}) : rem_sh[DSR_W-1:0];
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q[OUT_W-1:0];
endmodule

// File: rtl/synth_word_calc.sv
module synth_word_calc
    import wfc_pkg::*;
#(
    parameter int unsigned PFD_HZ = 3686400,
    parameter int unsigned IF_HZ  = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       rx_freq_hz,
    input  logic [31:0]       tx_freq_hz,
    input  logic [15:0]       afc_ofs_hz,
    input  logic              div2,
    input  logic              bidir_data,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rx_word,
    output logic [31:0]       tx_word
);
    logic [1:0][DVD_W-1:0] dvd;
    logic [DSR_W-1:0]      dsr;
    logic [1:0]            lane_busy;
    logic [1:0]            lane_done;
    logic [1:0][RES_W-1:0] quot;
    logic                  accept;
    logic                  bidir_q;

    wfc_target #(.PFD_HZ(PFD_HZ), .IF_HZ(IF_HZ)) u_target (
        .rx_freq (rx_freq_hz),
        .tx_freq (tx_freq_hz),
        .afc     (afc_ofs_hz),
        .div2    (div2),
        .dvd     (dvd),
        .dsr     (dsr)
    );

    for (genvar gi = 0; gi < 2; gi++) begin : g_lane
        wfc_divider #(.DVD_W(DVD_W), .DSR_W(DSR_W), .OUT_W(RES_W)) u_div (
            .clk  (clk),
            .rst  (rst),
            .load (accept),
            .dvd  (dvd[gi]),
            .dsr  (dsr),
            .busy (lane_busy[gi]),
            .done (lane_done[gi]),
            .quot (quot[gi])
        );
    end

    assign busy   = (|lane_busy) | (|lane_done);
    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            bidir_q <= 1'b0;
            done    <= 1'b0;
            rx_word <= '0;
            tx_word <= '0;
        end else begin
            done <= &lane_done;
            if (accept) bidir_q <= bidir_data;
            if (&lane_done) begin
                rx_word <= pack_word(LANE_RX, bidir_q, divs_t'(quot[LANE_RX]));
                tx_word <= pack_word(LANE_TX, bidir_q, divs_t'(quot[LANE_TX]));
            end
        end
    end
endmodule

// File: rtl/wfc_checker.sv
module wfc_checker #(
    parameter int LAT = 51
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] rx_word,
    input logic [31:0] tx_word
);
    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    assert_busy_len_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> busy_cnt < LAT);
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_at_end_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    assert_addr_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (rx_word[3:0] == 4'b0000 && tx_word[3:0] == 4'b0000));
    assert_ctrl_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (rx_word[31:29] == 3'b010 && rx_word[27] &&
                  tx_word[31:29] == 3'b010 && !tx_word[27] &&
                  rx_word[28] == tx_word[28]));
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(rx_word) && $stable(tx_word)));
endmodule

bind synth_word_calc wfc_checker #(.LAT(wfc_pkg::DVD_W + 1)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rx_word (rx_word),
    .tx_word (tx_word)
);

// File: tb/tb_synth_word_calc.sv
module tb_synth_word_calc;
    localparam longint PFD = 3686400;
    localparam int     LAT = 51;

    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic [31:0] rxf = '0;
    logic [31:0] txf = '0;
    logic [15:0] afc = '0;
    logic        d2 = 0;
    logic        bd = 0;
    logic        busy, done;
    logic [31:0] rx_word, tx_word;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    synth_word_calc dut (
        .clk(clk), .rst(rst), .start(start),
        .rx_freq_hz(rxf), .tx_freq_hz(txf), .afc_ofs_hz(afc),
        .div2(d2), .bidir_data(bd),
        .busy(busy), .done(done), .rx_word(rx_word), .tx_word(tx_word)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_word(bit is_rx, longint f, longint a, bit dd, bit bb);
        longint d, t, n, r, fr;
        logic [4:0] c;
        d = dd ? PFD : PFD / 2;
        t = is_rx ? (f - 100000 + (dd ? 2 * a : a)) : f;
        n = t / d;
        r = t % d;
        fr = (r * 32768 + d / 2) / d;
        if (fr == 32768) begin
            fr = 0;
            n = n + 1;
        end
        c = is_rx ? (bb ? 5'b01001 : 5'b01011) : (bb ? 5'b01000 : 5'b01010);
        return {c, n[7:0], fr[14:0], 4'b0000};
    endfunction

    task automatic run(input longint r, input longint t, input longint a,
                       input bit dd, input bit bb, input bit poke, input string tag);
        logic [31:0] er, et;
        er = ref_word(1, r, a, dd, bb);
        et = ref_word(0, t, a, dd, bb);
        @(negedge clk);
        rxf = r[31:0]; txf = t[31:0]; afc = a[15:0]; d2 = dd; bd = bb;
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy === 1'b1 && done === 1'b0, {"R2 accept ", tag}, {busy, done}, 2'b10);
        for (int k = 1; k < LAT; k++) begin
            @(negedge clk);
            chk(busy === 1'b1 && done === 1'b0, {"R2 busy ", tag}, {busy, done}, 2'b10);
            if (poke && k == 10) begin
                // R9: second start and new inputs mid-calculation
                rxf = 32'd150000000; txf = 32'd151000000; afc = 16'd999;
                d2 = ~dd; bd = ~bb; start = 1;
            end
            if (poke && k == 11) start = 0;
        end
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b1, {"R2 done ", tag}, {busy, done}, 2'b01);
        chk(rx_word === er, {"rx ", tag}, rx_word, er);
        chk(tx_word === et, {"tx ", tag}, tx_word, et);
        @(negedge clk);
        chk(done === 1'b0, {"R2 pulse ", tag}, done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 0 && done === 0 && rx_word === 0 && tx_word === 0,
            "R1 in reset", {busy, done, rx_word[15:0], tx_word[15:0]}, 0);
        rst = 0;
        @(negedge clk);
        chk(busy === 0 && done === 0 && rx_word === 0 && tx_word === 0,
            "R1 after reset", {busy, done, rx_word[15:0], tx_word[15:0]}, 0);

        run(434000000, 435000000, 0,   0, 0, 0, "R3 R5 R7 R8 plain");
        run(433450000, 433450000, 300, 0, 1, 0, "R3 R8 afc bidir");
        run(900000000, 910000000, 500, 1, 0, 0, "R4 div2");
        run(912345678, 899999999, 77,  1, 1, 0, "R4 R8 div2 bidir");

        // R6: remainder rounds to a full step -> F=0, N=237
        run(434000000, 436838380, 0, 0, 0, 0, "R6 carry");
        chk(tx_word[18:4] === 15'd0 && tx_word[26:19] === 8'd237,
            "R6 carry fields", {tx_word[26:19], tx_word[18:4]}, {8'd237, 15'd0});

        // R10: quotient 300 keeps low 8 bits (44)
        run(434000000, 552960000, 0, 0, 0, 0, "R10 wrap");
        chk(tx_word[26:19] === 8'd44, "R10 N field", tx_word[26:19], 8'd44);

        run(440000000, 441000000, 120, 0, 0, 1, "R9 ignored start");

        // R11: inputs change without start; words must hold
        begin
            logic [31:0] hr, ht;
            hr = rx_word; ht = tx_word;
            rxf = 32'd145000000; txf = 32'd146000000; afc = 16'd5; d2 = 1; bd = 1;
            repeat (10) @(negedge clk);
            chk(rx_word === hr && tx_word === ht && busy === 0,
                "R11 hold", {rx_word, tx_word}, {hr, ht});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule